// File: doc/BRIEF.md
# MII to RMII Transmit Converter

This block sits between the transmit side of an Ethernet MAC that speaks a four-bit MII and a PHY that takes the two-bit RMII. It runs entirely on the RMII reference clock (nominally 50 MHz). From that clock it derives the MII transmit clock it hands to the MAC. It samples the MAC's enable, error and nibble at the edge where that clock rises. It then sends each nibble to the PHY as two dibits on successive dibit slots.

A rate input selects between 100 Mbps and 10 Mbps operation. At 100 Mbps each dibit slot is one reference cycle, so the derived clock runs at half the reference rate. At 10 Mbps each slot is ten reference cycles, so every dibit is held for ten cycles and the derived clock toggles every ten cycles. If the MAC flags a transmit error, the block latches it. From then until the frame ends it sends a fixed filler dibit instead of data. The latch clears when the MAC drops enable.

The rate input is expected to change only while reset is asserted. The reset is asynchronous on assertion and is released through a two-stage synchronizer, so the block starts working on the third reference edge after `rst_n` rises.

Top module: `mii_rmii_tx_bridge`

## Requirements
- R1: While reset is asserted, and after reset until the first sample, `phy_tx_en` is 0, `phy_txd` is 00 and `mii_tx_clk` is 0.
- R2: At 100 Mbps (`rate_10m`=0), `mii_tx_clk` toggles on every reference edge from the third edge after reset release onward. The MAC inputs are sampled on each reference edge that raises `mii_tx_clk`.
- R3: For a nibble sampled with enable high and no error, `phy_txd` carries nibble bits [1:0] from the sampling edge. On the next dibit slot it carries bits [3:2].
- R4: If `mac_tx_er` is high at a sample with enable high, both dibits of that nibble and every later dibit are 01 for as long as enable stays high at later samples.
- R5: A sample with enable low clears the error state, so the next frame carries its data unchanged.
- R6: At 10 Mbps (`rate_10m`=1), dibit slots begin on the 10th, 20th, 30th, ... edge counted from the third edge after reset release as edge 1. `phy_txd` and `phy_tx_en` are held for the 10 cycles between slots, and `mii_tx_clk` toggles at each slot.
- R7: `phy_tx_en` rises with the first dibit of the first enabled nibble. It falls on the slot after the high dibit of the last enabled nibble, and it never changes at a high-dibit slot.
- R8: A nibble sampled with enable low produces two 00 dibits with `phy_tx_en` low. `mac_tx_er` with enable low has no effect on later frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | RMII reference clock, drives all logic |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rate_10m | input | 1 | 1 selects 10 Mbps pacing, 0 selects 100 Mbps |
| mii_tx_clk | output | 1 | Derived MII transmit clock for the MAC |
| mac_tx_en | input | 1 | MII transmit enable from the MAC |
| mac_tx_er | input | 1 | MII transmit error from the MAC |
| mac_txd | input | 4 | MII transmit nibble from the MAC |
| phy_tx_en | output | 1 | RMII transmit enable to the PHY |
| phy_txd | output | 2 | RMII transmit dibit to the PHY |

## Verification
The bench builds the block with its default ten-cycle slow divider. It switches `rate_10m` between runs under reset, so both the one-cycle and the ten-cycle dibit slots are compared against the reference model on every clock. With the default divider, a full 10 Mbps frame completes in a few hundred cycles. That brings the hold windows, the start of the first slot after reset and the enable edges at frame boundaries within reach, together with error onset mid-frame, error clearing between frames and error pulses while idle.

// File: rtl/mrtx_pkg.sv
package mrtx_pkg;
  localparam int DIB_W = 2;
  localparam int NIB_W = 2 * DIB_W;
  localparam logic [DIB_W-1:0] DIBIT_IDLE = 2'b00;
  localparam logic [DIB_W-1:0] DIBIT_ERR  = 2'b01;
endpackage

// File: rtl/mrtx_rst_sync.sv
module mrtx_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic s0_q, s1_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      s0_q <= 1'b1;
      s1_q <= s0_q;
    end
  end

  assign srst_n = s1_q;
endmodule

// File: rtl/mrtx_tick_gen.sv
module mrtx_tick_gen #(
  parameter int SLOW_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow,
  output logic tick,
  output logic phase
);
  localparam int CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOW_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          phase_q, phase_d;

  always_comb begin
    tick = slow ? (cnt_q == LAST) : 1'b1;
    if (!slow || cnt_q == LAST) cnt_d = '0;
    else                        cnt_d = cnt_q + 1'b1;
    phase_d = tick ? ~phase_q : phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign phase = phase_q;

  // R2: fast rate gives a slot every cycle
  p_fast_every_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !slow |-> tick);
  // R6: divider never leaves its range
  p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R6: derived clock only moves at slots
  p_phase_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase_q));
endmodule

// File: rtl/mrtx_serializer.sv
module mrtx_serializer
  import mrtx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             phase,
  input  logic             mac_en,
  input  logic             mac_er,
  input  logic [NIB_W-1:0] mac_d,
  output logic             phy_en,
  output logic [DIB_W-1:0] phy_d
);
  logic             en_q, en_d;
  logic             err_q, err_d;
  logic [DIB_W-1:0] hi_q, hi_d;
  logic [DIB_W-1:0] d_q, d_d;
  logic             sample, shift, err_now;

  always_comb begin
    sample  = tick & ~phase;
    shift   = tick & phase;
    err_now = mac_en & (mac_er | err_q);
    en_d    = en_q;
    err_d   = err_q;
    hi_d    = hi_q;
    d_d     = d_q;
    if (sample) begin
      en_d  = mac_en;
      err_d = err_now;
      hi_d  = mac_d[NIB_W-1:DIB_W];
      if (!mac_en)      d_d = DIBIT_IDLE;
      else if (err_now) d_d = DIBIT_ERR;
      else              d_d = mac_d[DIB_W-1:0];
    end else if (shift) begin
      if (!en_q)      d_d = DIBIT_IDLE;
      else if (err_q) d_d = DIBIT_ERR;
      else            d_d = hi_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      err_q <= 1'b0;
      hi_q  <= DIBIT_IDLE;
      d_q   <= DIBIT_IDLE;
    end else begin
      en_q  <= en_d;
      err_q <= err_d;
      hi_q  <= hi_d;
      d_q   <= d_d;
    end
  end

  assign phy_en = en_q;
  assign phy_d  = d_q;

  // R4: latched error forces the filler dibit
  p_err_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && en_q) |-> (d_q == DIBIT_ERR));
  // R5: error state never outlives the frame
  p_err_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> en_q);
  // R8: idle line carries 00
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (d_q == DIBIT_IDLE));
  // R6: outputs held between slots
  p_hold_between_slots_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(d_q) && $stable(en_q)));
  // R7: enable only moves at nibble boundaries
  p_en_nibble_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && phase) |=> $stable(en_q));
endmodule

// File: rtl/mii_rmii_tx_bridge.sv
module mii_rmii_tx_bridge #(
  parameter int SLOW_DIV = 10
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       rate_10m,
  output logic       mii_tx_clk,
  input  logic       mac_tx_en,
  input  logic       mac_tx_er,
  input  logic [3:0] mac_txd,
  output logic       phy_tx_en,
  output logic [1:0] phy_txd
);
  logic srst_n;
  logic tick;
  logic phase;

  mrtx_rst_sync u_rst (
    .clk    (ref_clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  mrtx_tick_gen #(.SLOW_DIV(SLOW_DIV)) u_tick (
    .clk   (ref_clk),
    .rst_n (srst_n),
    .slow  (rate_10m),
    .tick  (tick),
    .phase (phase)
  );

  mrtx_serializer u_ser (
    .clk    (ref_clk),
    .rst_n  (srst_n),
    .tick   (tick),
    .phase  (phase),
    .mac_en (mac_tx_en),
    .mac_er (mac_tx_er),
    .mac_d  (mac_txd),
    .phy_en (phy_tx_en),
    .phy_d  (phy_txd)
  );

  assign mii_tx_clk = phase;

  // R1: quiet outputs while in reset
  p_reset_quiet_r1: assert property (@(posedge ref_clk)
    !srst_n |-> (!phy_tx_en && phy_txd == 2'b00 && !mii_tx_clk));
endmodule

// File: tb/mii_rmii_tx_bridge_tb.sv
module mii_rmii_tx_bridge_tb;
  logic       ref_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rate_10m = 1'b0;
  logic       mac_tx_en = 1'b0;
  logic       mac_tx_er = 1'b0;
  logic [3:0] mac_txd = 4'h0;
  logic       mii_tx_clk;
  logic       phy_tx_en;
  logic [1:0] phy_txd;

  int checks = 0;
  int fails = 0;
  string cur_tag = "R1";

  always #4 ref_clk = ~ref_clk;

  mii_rmii_tx_bridge u_dut (
    .ref_clk    (ref_clk),
    .rst_n      (rst_n),
    .rate_10m   (rate_10m),
    .mii_tx_clk (mii_tx_clk),
    .mac_tx_en  (mac_tx_en),
    .mac_tx_er  (mac_tx_er),
    .mac_txd    (mac_txd),
    .phy_tx_en  (phy_tx_en),
    .phy_txd    (phy_txd)
  );

  // behavioural reference model
  int       edges = 0;
  bit       m_ph, m_en, m_err;
  bit [1:0] m_hi, m_txd;

  always @(posedge ref_clk) begin
    if (!rst_n) begin
      edges = 0; m_ph = 0; m_en = 0; m_err = 0; m_hi = 0; m_txd = 0;
    end else begin
      edges++;
      if (edges >= 3) begin
        int fn;
        bit slot;
        fn = edges - 2;
        slot = rate_10m ? (fn % 10 == 0) : 1'b1;
        if (slot) begin
          if (!m_ph) begin
            m_err = mac_tx_en && (mac_tx_er || m_err);
            m_en  = mac_tx_en;
            m_hi  = mac_txd[3:2];
            m_txd = !mac_tx_en ? 2'b00 : (m_err ? 2'b01 : mac_txd[1:0]);
            m_ph  = 1;
          end else begin
            m_txd = !m_en ? 2'b00 : (m_err ? 2'b01 : m_hi);
            m_ph  = 0;
          end
        end
      end
    end
  end

  always @(negedge ref_clk) begin
    string tg;
    checks++;
    tg = !rst_n ? "R1" : cur_tag;
    if (phy_txd !== m_txd) begin
      fails++;
      $display("FAIL %s phy_txd actual %b expected %b at %0t", tg, phy_txd, m_txd, $time);
    end
    checks++;
    if (phy_tx_en !== m_en) begin
      fails++;
      $display("FAIL %s/R7 phy_tx_en actual %b expected %b at %0t", tg, phy_tx_en, m_en, $time);
    end
    checks++;
    if (mii_tx_clk !== m_ph) begin
      fails++;
      $display("FAIL %s mii_tx_clk actual %b expected %b at %0t", rate_10m ? "R6" : "R2",
               mii_tx_clk, m_ph, $time);
    end
  end

  task automatic nib(input bit en, input bit er, input bit [3:0] d);
    mac_tx_en = en; mac_tx_er = er; mac_txd = d;
    @(posedge mii_tx_clk);
    @(negedge ref_clk);
  endtask

  task automatic frame(input int n, input int err_at);
    for (int i = 0; i < n; i++) nib(1'b1, i == err_at, 4'($urandom));
    nib(1'b0, 1'b0, 4'h0);
    nib(1'b0, 1'b0, 4'h0);
  endtask

  task automatic do_reset(input bit slow);
    @(negedge ref_clk);
    rst_n = 1'b0; rate_10m = slow; mac_tx_en = 0; mac_tx_er = 0;
    cur_tag = "R1";
    repeat (4) @(negedge ref_clk);
    rst_n = 1'b1;
    repeat (2) @(negedge ref_clk);
  endtask

  initial begin
    do_reset(1'b0);
    cur_tag = "R8";
    nib(1'b0, 1'b1, 4'hF);
    nib(1'b0, 1'b1, 4'hA);
    cur_tag = "R3";
    nib(1'b1, 1'b0, 4'b1001);
    nib(1'b1, 1'b0, 4'b0110);
    frame(12, -1);
    cur_tag = "R4";
    frame(10, 4);
    frame(6, 0);
    cur_tag = "R5";
    frame(10, -1);
    cur_tag = "R8";
    nib(1'b0, 1'b1, 4'h7);
    cur_tag = "R3";
    frame(8, -1);
    do_reset(1'b1);
    cur_tag = "R6";
    nib(1'b0, 1'b1, 4'h3);
    frame(6, -1);
    cur_tag = "R4";
    frame(6, 2);
    cur_tag = "R5";
    frame(5, -1);
    repeat (5) @(negedge ref_clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge ref_clk);
    fails++;
    $display("FAIL watchdog expired, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule